// File: doc/BRIEF.md
# NOR Flash Program and Erase Engine

This block carries out modify operations on a small on-chip byte array that behaves like NOR flash: a program can only turn ones into zeros, and the only way back to ones is an erase of an aligned region. The array size and every region size are parameters, so a shrunk copy keeps the same nesting of a page inside a small subsector, a small subsector inside a large one, a large one inside a sector, and sectors inside the whole array. A separate one-time-programmable (OTP) area of 64 data bytes and one control byte sits beside the main array and has its own program command.

A host presents one command per cycle with an opcode, an address, a length and a page of data. The engine needs its write-enable latch set before any modify command. It then steps through the target bytes one per clock, holding busy for the whole run, and pulses done when it finishes. A registered read port gives access to both the main array and the OTP area at any time.

Top module: `flash_pe_engine`

## Requirements
- R1: After reset busy, wel, done and rej are 0, rd_data is 8'hFF, every main-array byte and every OTP byte (control byte included) reads 8'hFF, and the OTP area is unlocked.
- R2: Opcode 1 sets wel. A modify command (opcodes 3 to 8) issued while idle with wel clear is refused: rej is 1 for the following cycle, busy stays 0 and no byte changes.
- R3: Program (opcode 3) writes old AND new into each target byte, so a bit already at 0 is never set back to 1. Byte k of the run takes cmd_data[8k+7:8k].
- R4: A program of cmd_len+1 bytes starts at cmd_addr and advances only the low PAGE_W address bits, so it wraps to the start of the same 16-byte page and never touches the next page.
- R5: An accepted command with N byte steps holds busy for exactly N cycles, starting in the cycle after acceptance. In the first cycle with busy low, done is 1 for that one cycle and wel is 0. A program takes cmd_len+1 steps.
- R6: Opcodes 4, 5, 6 and 7 erase an aligned region of 64, 128 or 256 bytes, or the whole array. The region contains cmd_addr, with the low address bits masked off. Every byte of the region becomes 8'hFF, one byte per step, and bytes outside it are unchanged.
- R7: While busy, any command with a non-zero opcode is refused with a one-cycle rej pulse and does not disturb the running operation.
- R8: OTP program (opcode 8) ANDs byte k of cmd_data into OTP index (cmd_addr+k) mod 128. Indices 0 to 63 are data and index 64 is the control byte. Higher indices are dropped but still take a step.
- R9: Once bit 0 of the OTP control byte is 0, the OTP area is locked. Every later OTP program runs its steps but changes no OTP byte. The main array stays programmable.
- R10: rd_data shows, one cycle after rd_otp and rd_addr are sampled, the main-array byte or the OTP byte at index rd_addr mod 128. OTP indices above 64 read 8'hFF.
- R11: Opcode 2 clears wel when idle. Opcode 0, and opcodes 9 to 15 when idle, have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 4 | Opcode |
| cmd_addr | input | ADDR_W | Byte address or OTP index |
| cmd_len | input | PAGE_W | Program length minus one |
| cmd_data | input | 8<<PAGE_W | Page data, byte k in bits 8k+7:8k |
| rd_otp | input | 1 | Read selects the OTP area |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | 8 | Registered read data |
| busy | output | 1 | Operation in progress |
| wel | output | 1 | Write-enable latch |
| done | output | 1 | One-cycle completion pulse |
| rej | output | 1 | One-cycle command refusal pulse |

## Verification
The hardest situations to reach from the ports are a refused command landing in the middle of a long run, and an OTP program that arrives after the control byte has been cleared. The stimulus first issues a 16-byte program and injects further commands while busy is high. It then clears bit 0 of the control byte through the ordinary OTP program path and follows with a fresh write-enable and a second OTP program. Nested erases are staged with marker bytes just outside each region, so that wrong masking at any level shows up as a changed marker.

// File: rtl/flash_pe_pkg.sv
package flash_pe_pkg;

  typedef enum logic [3:0] {
    OP_NOP      = 4'd0,
    OP_WREN     = 4'd1,
    OP_WRDI     = 4'd2,
    OP_PROG     = 4'd3,
    OP_ER_SMALL = 4'd4,
    OP_ER_LARGE = 4'd5,
    OP_ER_SECT  = 4'd6,
    OP_ER_ALL   = 4'd7,
    OP_OTP_PROG = 4'd8
  } fpe_op_e;

  typedef enum logic [1:0] {
    JOB_PROG  = 2'd0,
    JOB_ERASE = 2'd1,
    JOB_OTP   = 2'd2
  } fpe_job_e;

endpackage

// File: rtl/fpe_region.sv
module fpe_region
  import flash_pe_pkg::*;
#(
  parameter int ADDR_W = 9,
  parameter int SSUB_W = 6,
  parameter int LSUB_W = 7,
  parameter int SECT_W = 8
) (
  input  fpe_op_e           op,
  input  logic [ADDR_W-1:0] addr,
  output logic [ADDR_W-1:0] base,
  output logic [ADDR_W-1:0] last
);

  localparam logic [ADDR_W-1:0] ALL_ONES  = {ADDR_W{1'b1}};
  localparam logic [ADDR_W-1:0] SSUB_LAST = ALL_ONES >> (ADDR_W - SSUB_W);
  localparam logic [ADDR_W-1:0] LSUB_LAST = ALL_ONES >> (ADDR_W - LSUB_W);
  localparam logic [ADDR_W-1:0] SECT_LAST = ALL_ONES >> (ADDR_W - SECT_W);

  always_comb begin
    case (op)
      OP_ER_SMALL: last = SSUB_LAST;
      OP_ER_LARGE: last = LSUB_LAST;
      OP_ER_SECT:  last = SECT_LAST;
      default:     last = ALL_ONES;
    endcase
    base = addr & ~last;
  end

endmodule

// File: rtl/fpe_ctrl.sv
module fpe_ctrl
  import flash_pe_pkg::*;
#(
  parameter int ADDR_W = 9,
  parameter int PAGE_W = 4,
  parameter int OTP_AW = 7
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        cmd_valid,
  input  fpe_op_e                     op,
  input  logic [ADDR_W-1:0]           addr,
  input  logic [PAGE_W-1:0]           len,
  input  logic [(8<<PAGE_W)-1:0]      data,
  input  logic [ADDR_W-1:0]           region_base,
  input  logic [ADDR_W-1:0]           region_last,
  output logic                        busy,
  output logic                        wel,
  output logic                        done,
  output logic                        rej,
  output logic                        we,
  output logic                        w_otp,
  output logic                        w_erase,
  output logic [ADDR_W-1:0]           w_addr,
  output logic [7:0]                  w_data
);

  localparam int PAGE_BITS = 8 << PAGE_W;

  logic                 busy_q, busy_d;
  logic                 wel_q, wel_d;
  logic                 done_q, done_d;
  logic                 rej_q, rej_d;
  fpe_job_e             job_q, job_d;
  logic [ADDR_W-1:0]    cnt_q, cnt_d;
  logic [ADDR_W-1:0]    last_q, last_d;
  logic [ADDR_W-1:0]    start_q, start_d;
  logic [PAGE_BITS-1:0] page_q;
  logic                 page_en;

  logic is_mod, accept, finish;
  logic [PAGE_W-1:0] page_step;
  logic [OTP_AW-1:0] otp_step;

  always_comb begin
    case (op)
      OP_PROG, OP_ER_SMALL, OP_ER_LARGE, OP_ER_SECT, OP_ER_ALL, OP_OTP_PROG: is_mod = 1'b1;
      default: is_mod = 1'b0;
    endcase
  end

  assign accept = cmd_valid && !busy_q && is_mod && wel_q;
  assign finish = busy_q && (cnt_q == last_q);

  // next-state
  always_comb begin
    busy_d  = busy_q;
    wel_d   = wel_q;
    cnt_d   = cnt_q;
    job_d   = job_q;
    start_d = start_q;
    last_d  = last_q;
    page_en = accept;
    done_d  = finish;
    rej_d   = cmd_valid && (busy_q ? (op != OP_NOP) : (is_mod && !wel_q));
    if (busy_q) begin
      cnt_d = cnt_q + 1'b1;
      if (finish) begin
        busy_d = 1'b0;
        wel_d  = 1'b0;
      end
    end else if (cmd_valid) begin
      case (op)
        OP_WREN: wel_d = 1'b1;
        OP_WRDI: wel_d = 1'b0;
        default: wel_d = wel_q;
      endcase
      if (accept) begin
        busy_d = 1'b1;
        cnt_d  = '0;
        case (op)
          OP_PROG: begin
            job_d   = JOB_PROG;
            start_d = addr;
            last_d  = ADDR_W'(len);
          end
          OP_OTP_PROG: begin
            job_d   = JOB_OTP;
            start_d = addr;
            last_d  = ADDR_W'(len);
          end
          default: begin
            job_d   = JOB_ERASE;
            start_d = region_base;
            last_d  = region_last;
          end
        endcase
      end
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      wel_q   <= 1'b0;
      done_q  <= 1'b0;
      rej_q   <= 1'b0;
      job_q   <= JOB_PROG;
      cnt_q   <= '0;
      last_q  <= '0;
      start_q <= '0;
    end else begin
      busy_q  <= busy_d;
      wel_q   <= wel_d;
      done_q  <= done_d;
      rej_q   <= rej_d;
      job_q   <= job_d;
      cnt_q   <= cnt_d;
      last_q  <= last_d;
      start_q <= start_d;
    end
  end

  always_ff @(posedge clk) begin
    if (page_en) page_q <= data;
  end

  // write port
  assign page_step = start_q[PAGE_W-1:0] + cnt_q[PAGE_W-1:0];
  assign otp_step  = start_q[OTP_AW-1:0] + cnt_q[OTP_AW-1:0];

  always_comb begin
    case (job_q)
      JOB_PROG:  w_addr = {start_q[ADDR_W-1:PAGE_W], page_step};
      JOB_OTP:   w_addr = ADDR_W'(otp_step);
      default:   w_addr = start_q | cnt_q;
    endcase
  end

  assign w_data  = (job_q == JOB_ERASE) ? 8'hFF : page_q[{cnt_q[PAGE_W-1:0], 3'b000} +: 8];
  assign w_erase = (job_q == JOB_ERASE);
  assign w_otp   = (job_q == JOB_OTP);
  assign we      = busy_q;

  assign busy = busy_q;
  assign wel  = wel_q;
  assign done = done_q;
  assign rej  = rej_q;

  assert_start_needs_wel_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> $past(wel_q));

  assert_done_follows_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (!busy_q && $past(busy_q)));

  assert_wel_cleared_at_end_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> !wel_q);

  assert_no_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && busy_q && !finish) |=> (busy_q && (cnt_q == $past(cnt_q) + 1'b1)));

endmodule

// File: rtl/fpe_store.sv
module fpe_store #(
  parameter int ADDR_W    = 9,
  parameter int OTP_BYTES = 64,
  parameter int OTP_AW    = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic              w_otp,
  input  logic              w_erase,
  input  logic [ADDR_W-1:0] w_addr,
  input  logic [7:0]        w_data,
  input  logic              rd_otp,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data
);

  localparam int DEPTH    = 1 << ADDR_W;
  localparam int CTRL_IDX = OTP_BYTES;

  logic [7:0] mem_q [DEPTH];
  logic [7:0] otp_q [OTP_BYTES+1];
  logic [7:0] rd_q, rd_d;

  logic              locked;
  logic              mem_we, otp_we;
  logic [7:0]        mem_old, mem_wd, otp_old, otp_wd, otp_rd;
  logic [OTP_AW-1:0] otp_widx, otp_ridx;

  assign locked   = ~otp_q[CTRL_IDX][0];
  assign otp_widx = w_addr[OTP_AW-1:0];
  assign otp_ridx = rd_addr[OTP_AW-1:0];

  always_comb begin
    mem_old = mem_q[w_addr];
    mem_we  = we && !w_otp;
    mem_wd  = w_erase ? 8'hFF : (mem_old & w_data);
    otp_old = (int'(otp_widx) <= CTRL_IDX) ? otp_q[otp_widx] : 8'hFF;
    otp_we  = we && w_otp && (int'(otp_widx) <= CTRL_IDX) && !locked;
    otp_wd  = otp_old & w_data;
    otp_rd  = (int'(otp_ridx) <= CTRL_IDX) ? otp_q[otp_ridx] : 8'hFF;
    rd_d    = rd_otp ? otp_rd : mem_q[rd_addr];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= 8'hFF;
    end else if (mem_we) begin
      mem_q[w_addr] <= mem_wd;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i <= CTRL_IDX; i++) otp_q[i] <= 8'hFF;
    end else if (otp_we) begin
      otp_q[otp_widx] <= otp_wd;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_q <= 8'hFF;
    else        rd_q <= rd_d;
  end

  assign rd_data = rd_q;

  assert_prog_only_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && !w_erase) |=> ((mem_q[$past(w_addr)] & ~$past(mem_old)) == 8'h00));

  assert_erase_sets_ones_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && w_erase) |=> (mem_q[$past(w_addr)] == 8'hFF));

  assert_lock_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> locked);

endmodule

// File: rtl/flash_pe_engine.sv
module flash_pe_engine
  import flash_pe_pkg::*;
#(
  parameter int ADDR_W    = 9,
  parameter int PAGE_W    = 4,
  parameter int SSUB_W    = 6,
  parameter int LSUB_W    = 7,
  parameter int SECT_W    = 8,
  parameter int OTP_BYTES = 64
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cmd_valid,
  input  logic [3:0]             cmd_op,
  input  logic [ADDR_W-1:0]      cmd_addr,
  input  logic [PAGE_W-1:0]      cmd_len,
  input  logic [(8<<PAGE_W)-1:0] cmd_data,
  input  logic                   rd_otp,
  input  logic [ADDR_W-1:0]      rd_addr,
  output logic [7:0]             rd_data,
  output logic                   busy,
  output logic                   wel,
  output logic                   done,
  output logic                   rej
);

  localparam int OTP_AW = $clog2(OTP_BYTES + 1);

  fpe_op_e           op_e;
  logic [ADDR_W-1:0] region_base, region_last;
  logic              we, w_otp, w_erase;
  logic [ADDR_W-1:0] w_addr;
  logic [7:0]        w_data;

  assign op_e = fpe_op_e'(cmd_op);

  fpe_region #(
    .ADDR_W(ADDR_W), .SSUB_W(SSUB_W), .LSUB_W(LSUB_W), .SECT_W(SECT_W)
  ) u_region (
    .op(op_e), .addr(cmd_addr), .base(region_base), .last(region_last)
  );

  fpe_ctrl #(
    .ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .OTP_AW(OTP_AW)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .op(op_e),
    .addr(cmd_addr), .len(cmd_len), .data(cmd_data),
    .region_base(region_base), .region_last(region_last),
    .busy(busy), .wel(wel), .done(done), .rej(rej),
    .we(we), .w_otp(w_otp), .w_erase(w_erase), .w_addr(w_addr), .w_data(w_data)
  );

  fpe_store #(
    .ADDR_W(ADDR_W), .OTP_BYTES(OTP_BYTES), .OTP_AW(OTP_AW)
  ) u_store (
    .clk(clk), .rst_n(rst_n), .we(we), .w_otp(w_otp), .w_erase(w_erase),
    .w_addr(w_addr), .w_data(w_data),
    .rd_otp(rd_otp), .rd_addr(rd_addr), .rd_data(rd_data)
  );

endmodule

// File: tb/tb_flash_pe_engine.sv
module tb_flash_pe_engine;

  localparam int AW = 9;
  localparam int PW = 4;
  localparam int DW = 8 << PW;

  logic          clk, rst_n;
  logic          cmd_valid;
  logic [3:0]    cmd_op;
  logic [AW-1:0] cmd_addr;
  logic [PW-1:0] cmd_len;
  logic [DW-1:0] cmd_data;
  logic          rd_otp;
  logic [AW-1:0] rd_addr;
  logic [7:0]    rd_data;
  logic          busy, wel, done, rej;

  flash_pe_engine dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .cmd_len(cmd_len), .cmd_data(cmd_data),
    .rd_otp(rd_otp), .rd_addr(rd_addr), .rd_data(rd_data),
    .busy(busy), .wel(wel), .done(done), .rej(rej)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int total = 0;
  int bad = 0;
  bit finished = 0;
  int cyc = 0;

  task automatic chk(input int act, input int exp, input string tag);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // behavioural reference model
  int mm [512];
  int mo [65];
  int qa[$], qd[$], qo[$];
  bit mwel, mdone, mrej;
  int mrd;
  int pa, pd, po, sz, bs, ri;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 512; i++) mm[i] = 255;
      for (int i = 0; i < 65; i++) mo[i] = 255;
      qa.delete(); qd.delete(); qo.delete();
      mwel = 0; mdone = 0; mrej = 0; mrd = 255;
    end else begin
      ri = int'(rd_addr) % 128;
      mrd = rd_otp ? ((ri <= 64) ? mo[ri] : 255) : mm[int'(rd_addr)];
      mdone = 0; mrej = 0;
      if (qa.size() > 0) begin
        pa = qa.pop_front(); pd = qd.pop_front(); po = qo.pop_front();
        if (po != 0) begin
          if (pa <= 64 && (mo[64] & 1) == 1) mo[pa] = mo[pa] & pd;
        end else if (pd < 0) mm[pa] = 255;
        else mm[pa] = mm[pa] & pd;
        if (qa.size() == 0) begin mdone = 1; mwel = 0; end
        if (cmd_valid && cmd_op != 0) mrej = 1;
      end else if (cmd_valid) begin
        case (int'(cmd_op))
          1: mwel = 1;
          2: mwel = 0;
          3, 4, 5, 6, 7, 8: begin
            if (!mwel) mrej = 1;
            else if (cmd_op == 3) begin
              for (int k = 0; k <= int'(cmd_len); k++) begin
                qa.push_back((int'(cmd_addr) & ~15) | ((int'(cmd_addr) + k) & 15));
                qd.push_back(int'(cmd_data[8*k +: 8]));
                qo.push_back(0);
              end
            end else if (cmd_op == 8) begin
              for (int k = 0; k <= int'(cmd_len); k++) begin
                qa.push_back((int'(cmd_addr) + k) % 128);
                qd.push_back(int'(cmd_data[8*k +: 8]));
                qo.push_back(1);
              end
            end else begin
              sz = (cmd_op == 4) ? 64 : (cmd_op == 5) ? 128 : (cmd_op == 6) ? 256 : 512;
              bs = int'(cmd_addr) - (int'(cmd_addr) % sz);
              for (int i = 0; i < sz; i++) begin
                qa.push_back(bs + i); qd.push_back(-1); qo.push_back(0);
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  // compare every clock
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk(int'(busy), int'(qa.size() > 0), "R5 busy");
      chk(int'(wel), int'(mwel), "R2 wel");
      chk(int'(done), int'(mdone), "R5 done");
      chk(int'(rej), int'(mrej), "R7 rej");
      chk(int'(rd_data), mrd, "R10 rd_data");
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL R5 watchdog actual=busy expected=idle");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic issue(input int op, input int addr, input int len, input logic [DW-1:0] data);
    @(negedge clk);
    cmd_valid = 1; cmd_op = 4'(op); cmd_addr = AW'(addr); cmd_len = PW'(len); cmd_data = data;
    @(negedge clk);
    cmd_valid = 0; cmd_op = 0;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  task automatic run_count(input int op, input int addr, input int len,
                           input logic [DW-1:0] data, input int exp_n, input string tag);
    int n;
    issue(op, addr, len, data);
    n = 0;
    while (busy) begin n++; @(negedge clk); end
    chk(n, exp_n, tag);
    chk(int'(done), 1, tag);
    chk(int'(wel), 0, tag);
  endtask

  task automatic rd_chk(input bit otp, input int addr, input int exp, input string tag);
    wait_idle();
    @(negedge clk);
    rd_otp = otp; rd_addr = AW'(addr);
    @(negedge clk);
    chk(int'(rd_data), exp, tag);
  endtask

  initial begin
    rst_n = 0; cmd_valid = 0; cmd_op = 0; cmd_addr = 0; cmd_len = 0; cmd_data = '0;
    rd_otp = 0; rd_addr = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(int'(busy), 0, "R1 busy");
    chk(int'(wel), 0, "R1 wel");
    chk(int'(rd_data), 8'hFF, "R1 rd_data");
    rd_chk(0, 5, 8'hFF, "R1 array");
    rd_chk(1, 64, 8'hFF, "R1 otp control");

    // R2 refused without write enable
    issue(3, 8'h23, 0, 128'h00);
    chk(int'(rej), 1, "R2 refuse");
    chk(int'(busy), 0, "R2 no busy");
    rd_chk(0, 8'h23, 8'hFF, "R2 unchanged");

    // R3 / R5 program
    issue(1, 0, 0, '0);
    chk(int'(wel), 1, "R2 wren");
    run_count(3, 8'h23, 3, 128'hFF0F3CA5, 4, "R5 prog steps");
    rd_chk(0, 8'h23, 8'hA5, "R3 byte0");
    rd_chk(0, 8'h24, 8'h3C, "R3 byte1");
    issue(1, 0, 0, '0);
    run_count(3, 8'h23, 0, 128'hF0, 1, "R5 single step");
    rd_chk(0, 8'h23, 8'hA0, "R3 and");

    // R4 page wrap
    issue(1, 0, 0, '0);
    run_count(3, 8'h2E, 3, 128'h44332211, 4, "R4 steps");
    rd_chk(0, 8'h2F, 8'h22, "R4 before wrap");
    rd_chk(0, 8'h20, 8'h33, "R4 wrapped");
    rd_chk(0, 8'h30, 8'hFF, "R4 next page");

    // R7 refusal during busy
    issue(1, 0, 0, '0);
    issue(3, 9'h050, 15, {16{8'h0F}});
    issue(3, 9'h100, 0, 128'h00);
    chk(int'(rej), 1, "R7 busy refuse");
    chk(int'(busy), 1, "R7 still busy");
    issue(1, 0, 0, '0);
    chk(int'(rej), 1, "R7 wren refuse");
    rd_chk(0, 9'h100, 8'hFF, "R7 no effect");
    rd_chk(0, 9'h05F, 8'h0F, "R7 run complete");

    // R6 nested erases
    issue(1, 0, 0, '0);
    run_count(3, 8'h40, 0, 128'h00, 1, "R6 marker");
    issue(1, 0, 0, '0);
    run_count(4, 8'h2A, 0, '0, 64, "R6 small steps");
    rd_chk(0, 8'h23, 8'hFF, "R6 small erased");
    rd_chk(0, 8'h20, 8'hFF, "R6 small erased wrap");
    rd_chk(0, 8'h40, 8'h00, "R6 small boundary");
    issue(1, 0, 0, '0);
    run_count(5, 8'h45, 0, '0, 128, "R6 large steps");
    rd_chk(0, 8'h40, 8'hFF, "R6 large erased");
    issue(1, 0, 0, '0);
    run_count(3, 8'h80, 0, 128'h00, 1, "R6 marker2");
    issue(1, 0, 0, '0);
    run_count(3, 9'h1F0, 0, 128'h00, 1, "R6 marker3");
    issue(1, 0, 0, '0);
    run_count(6, 8'h90, 0, '0, 256, "R6 sector steps");
    rd_chk(0, 8'h80, 8'hFF, "R6 sector erased");
    rd_chk(0, 9'h1F0, 8'h00, "R6 sector boundary");
    issue(1, 0, 0, '0);
    run_count(7, 9'h123, 0, '0, 512, "R6 all steps");
    rd_chk(0, 9'h1F0, 8'hFF, "R6 all erased");

    // R8 OTP program, R10 reads
    issue(1, 0, 0, '0);
    run_count(8, 3, 1, 128'hC35A, 2, "R8 steps");
    rd_chk(1, 3, 8'h5A, "R8 otp3");
    rd_chk(1, 4, 8'hC3, "R8 otp4");
    rd_chk(1, 70, 8'hFF, "R10 above control");
    rd_chk(0, 3, 8'hFF, "R8 main untouched");

    // R9 lock
    issue(1, 0, 0, '0);
    run_count(8, 64, 0, 128'hFE, 1, "R9 lock write");
    rd_chk(1, 64, 8'hFE, "R9 control");
    issue(1, 0, 0, '0);
    run_count(8, 3, 0, 128'h00, 1, "R9 locked steps");
    rd_chk(1, 3, 8'h5A, "R9 locked ignore");
    issue(1, 0, 0, '0);
    run_count(3, 8'h10, 0, 128'h77, 1, "R9 main steps");
    rd_chk(0, 8'h10, 8'h77, "R9 main still works");

    // R11 write disable and idle no-ops
    issue(1, 0, 0, '0);
    issue(2, 0, 0, '0);
    chk(int'(wel), 0, "R11 wrdi");
    issue(3, 8'h11, 0, 128'h00);
    chk(int'(rej), 1, "R11 refuse after wrdi");
    issue(12, 0, 0, '0);
    chk(int'(rej), 0, "R11 unknown idle");
    chk(int'(busy), 0, "R11 unknown idle busy");
    rd_chk(0, 8'h11, 8'hFF, "R11 unchanged");

    repeat (3) @(negedge clk);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule